// File: doc/BRIEF.md
# Serial Byte Memory Slave with Pause and Status Lock

This block is the serial front end and control logic of a small byte-wide memory that answers as an SPI mode-0 slave. A host lowers chip select, shifts in a one-byte command and, for array accesses, a 16-bit address field. Data then streams in or out, one byte after another, while an internal address counter advances. A status register holds a write-enable latch and two block-protect bits. A write-protect pin can freeze those bits. A hold pin lets the host pause a transaction partway through and resume it later without losing its place.

All serial pins are sampled by a fast system clock through a two-stage synchronizer, and SCK edges are detected from the synchronized samples. The serial output has its own enable so that it can share a wire with the serial input. The enable is high only while read data or status is being shifted out.

The control state machine has these states. IDLE waits for chip select. OPCODE collects the command byte. ADDR collects 16 address bits. WRDATA and RDDATA stream array bytes. SRWR takes one status byte. SRRD streams status. SKIP discards the bits left in a command. A falling chip select moves any state to OPCODE. A rising chip select moves any state to IDLE. OPCODE goes to ADDR on a read or write command, to SRRD on a status read, to SRWR on a status write, and to SKIP on any other byte. ADDR goes to RDDATA or WRDATA once the sixteenth bit is in. SRWR goes to SKIP after its byte.

Top module: `spimem_slave`

## Requirements
- R1: While chip select is high, the output enable is low, and SCK and SI pulses change no state.
- R2: A falling chip select starts a new command with the opcode byte. A rising chip select ends the command and discards any partial byte, so a write cut off mid-byte stores nothing.
- R3: Command bytes: 0x06 sets the write-enable latch, 0x04 clears it, 0x05 reads status, 0x01 writes status, 0x03 reads the array and 0x02 writes the array. Any other byte is ignored.
- R4: A read (0x03) takes a 16-bit address, MSB first, whose upper 3 bits are ignored. Data bytes then come out MSB first, changing after SCK falls. The output enable stays low during the opcode and address phases.
- R5: An array write stores a byte only while the write-enable latch is set. The latch clears when chip select rises after a 0x02 or 0x01 command.
- R6: The address counter steps after each data byte and wraps from 0x1FFF to 0x0000, both in write bursts and in read bursts.
- R7: The status byte reads as {4'b0, protect[1:0], latch, 1'b0}. A status write updates protect[1:0] from data bits 3:2 only when the latch is set and the write-protect pin is high.
- R8: Protect code 01 blocks writes where address bits 12:11 are 11. Code 10 blocks writes where address bit 12 is 1. Code 11 blocks every write. Code 00 blocks none.
- R9: While hold is low, the output enable is low and SCK is ignored. When hold rises again, the transaction continues where it stopped.
- R10: SCK may stop for any time within a command, and the command then completes normally.
- R11: After reset, the output enable is low, the latch is clear and the protect bits are 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idle low (mode 0) |
| si | input | 1 | Serial data in, taken on SCK rise |
| hold_n | input | 1 | Pause request, active low, changed only while SCK is low |
| wp_n | input | 1 | Write protect for the status register, active low |
| so | output | 1 | Serial data out, updated after SCK fall |
| so_en | output | 1 | Drive enable for so; low means high impedance |

## Verification
The bench goes after the cases where bit counting drifts. If SCK pulses during hold or while chip select is high were counted, the status or read data that follows would come back shifted. If a truncated command were not thrown away, the partial byte would be stored and the aborted location would read back changed. It checks that the address counter rolls over at 0x1FFF in both directions, and that the upper address bits really are ignored. A counter built to the wrong width would write and read the wrong bytes. It also combines the write-enable latch, the write-protect pin and every protect code. A design that forgot to clear the latch, or decoded the protected region wrongly, would either accept writes it should drop or drop writes it should accept.

// File: rtl/spimem_pkg.sv
package spimem_pkg;

    localparam logic [7:0] CMD_LATCH_ON  = 8'h06;
    localparam logic [7:0] CMD_LATCH_OFF = 8'h04;
    localparam logic [7:0] CMD_STAT_RD   = 8'h05;
    localparam logic [7:0] CMD_STAT_WR   = 8'h01;
    localparam logic [7:0] CMD_ARR_RD    = 8'h03;
    localparam logic [7:0] CMD_ARR_WR    = 8'h02;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_WRDATA,
        ST_RDDATA,
        ST_SRWR,
        ST_SRRD,
        ST_SKIP
    } fsm_state_e;

endpackage

// File: rtl/spimem_sync.sv
module spimem_sync #(
    parameter int             W       = 5,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/spimem_array.sv
module spimem_array #(
    parameter int STORE_AW = 11,
    parameter int DATA_W   = 8
) (
    input  logic                clk,
    input  logic                we,
    input  logic [STORE_AW-1:0] idx,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata
);

    localparam int DEPTH = 1 << STORE_AW;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[idx] <= wdata;
        end
    end

    assign rdata = cells[idx];

endmodule

// File: rtl/spimem_status.sv
module spimem_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       latch_set,
    input  logic       latch_clr,
    input  logic       stat_we_req,
    input  logic [1:0] stat_wbits,
    input  logic       wp_ok,
    input  logic [1:0] addr_top,
    output logic       latch_q,
    output logic [1:0] prot_q,
    output logic [7:0] status_byte,
    output logic       arr_wr_ok
);

    logic region_locked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= 1'b0;
            prot_q  <= 2'b00;
        end else begin
            if (latch_clr) begin
                latch_q <= 1'b0;
            end else if (latch_set) begin
                latch_q <= 1'b1;
            end
            if (stat_we_req && latch_q && wp_ok) begin
                prot_q <= stat_wbits;
            end
        end
    end

    always_comb begin
        unique case (prot_q)
            2'b00:   region_locked = 1'b0;
            2'b01:   region_locked = (addr_top == 2'b11);
            2'b10:   region_locked = addr_top[1];
            default: region_locked = 1'b1;
        endcase
    end

    assign arr_wr_ok   = latch_q && !region_locked;
    assign status_byte = {4'b0000, prot_q, latch_q, 1'b0};

endmodule

// File: rtl/spimem_fsm.sv
module spimem_fsm
    import spimem_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int FIELD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              cmd_start,
    input  logic              cmd_end,
    input  logic              bus_live,
    input  logic              si,
    input  logic [7:0]        status_byte,
    input  logic [7:0]        arr_rdata,
    output fsm_state_e        state_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [7:0]        wr_byte,
    output logic              arr_we_req,
    output logic              stat_we_req,
    output logic              latch_set,
    output logic              latch_clr,
    output logic              so,
    output logic              so_en
);

    localparam int CNT_W = $clog2(FIELD_W);

    fsm_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [7:0]       shift_q;
    logic [7:0]       out_q;
    logic             op_read_q;
    logic             wr_cmd_q;
    logic             load_pend_q;
    logic             drive_q;
    logic [7:0]       byte_in;
    logic             byte_last;
    logic             field_last;
    logic             opcode_done;
    logic             in_read;

    assign byte_in     = {shift_q[6:0], si};
    assign byte_last   = (cnt_q == CNT_W'(7));
    assign field_last  = (cnt_q == CNT_W'(FIELD_W - 1));
    assign opcode_done = sck_rise && (state_q == ST_OPCODE) && byte_last;
    assign in_read     = (state_q == ST_RDDATA) || (state_q == ST_SRRD);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (cmd_end) begin
            state_d = ST_IDLE;
        end else if (cmd_start) begin
            state_d = ST_OPCODE;
        end else if (sck_rise) begin
            unique case (state_q)
                ST_OPCODE: begin
                    if (byte_last) begin
                        if (byte_in == CMD_ARR_RD || byte_in == CMD_ARR_WR) begin
                            state_d = ST_ADDR;
                        end else if (byte_in == CMD_STAT_RD) begin
                            state_d = ST_SRRD;
                        end else if (byte_in == CMD_STAT_WR) begin
                            state_d = ST_SRWR;
                        end else begin
                            state_d = ST_SKIP;
                        end
                    end
                end
                ST_ADDR: begin
                    if (field_last) begin
                        state_d = op_read_q ? ST_RDDATA : ST_WRDATA;
                    end
                end
                ST_SRWR: begin
                    if (byte_last) begin
                        state_d = ST_SKIP;
                    end
                end
                ST_IDLE, ST_WRDATA, ST_RDDATA, ST_SRRD, ST_SKIP: begin
                    state_d = state_q;
                end
            endcase
        end
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            shift_q     <= '0;
            out_q       <= '0;
            addr_q      <= '0;
            op_read_q   <= 1'b0;
            wr_cmd_q    <= 1'b0;
            load_pend_q <= 1'b0;
            drive_q     <= 1'b0;
            so_en       <= 1'b0;
        end else begin
            so_en <= drive_q && bus_live && in_read;
            if (cmd_end || cmd_start) begin
                cnt_q       <= '0;
                load_pend_q <= 1'b0;
                drive_q     <= 1'b0;
                wr_cmd_q    <= 1'b0;
            end else begin
                if (sck_rise) begin
                    shift_q <= byte_in;
                    if ((state_q == ST_ADDR) ? field_last : byte_last) begin
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                    if (opcode_done) begin
                        op_read_q <= (byte_in == CMD_ARR_RD);
                        wr_cmd_q  <= (byte_in == CMD_ARR_WR) || (byte_in == CMD_STAT_WR);
                        if (byte_in == CMD_STAT_RD) begin
                            load_pend_q <= 1'b1;
                        end
                    end
                    if (state_q == ST_ADDR) begin
                        addr_q <= {addr_q[ADDR_W-2:0], si};
                        if (field_last && op_read_q) begin
                            load_pend_q <= 1'b1;
                        end
                    end
                    if (state_q == ST_WRDATA && byte_last) begin
                        addr_q <= addr_q + 1'b1;
                    end
                    if (in_read && byte_last) begin
                        load_pend_q <= 1'b1;
                    end
                end
                if (sck_fall && in_read) begin
                    if (load_pend_q) begin
                        out_q       <= (state_q == ST_SRRD) ? status_byte : arr_rdata;
                        load_pend_q <= 1'b0;
                        drive_q     <= 1'b1;
                        if (state_q == ST_RDDATA) begin
                            addr_q <= addr_q + 1'b1;
                        end
                    end else begin
                        out_q <= {out_q[6:0], 1'b0};
                    end
                end
            end
        end
    end

    // combinational outputs
    always_comb begin
        wr_byte     = byte_in;
        arr_we_req  = sck_rise && (state_q == ST_WRDATA) && byte_last;
        stat_we_req = sck_rise && (state_q == ST_SRWR) && byte_last;
        latch_set   = opcode_done && (byte_in == CMD_LATCH_ON);
        latch_clr   = (opcode_done && (byte_in == CMD_LATCH_OFF)) || (cmd_end && wr_cmd_q);
        so          = out_q[7];
    end

endmodule

// File: rtl/spimem_slave.sv
module spimem_slave
    import spimem_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int FIELD_W     = 16,
    parameter int STORE_AW    = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    input  logic wp_n,
    output logic so,
    output logic so_en
);

    localparam int PIN_N = 5;

    logic [PIN_N-1:0]  pins_s;
    logic              wp_s;
    logic              hold_s;
    logic              cs_s;
    logic              sck_s;
    logic              si_s;
    logic              sck_prev_q;
    logic              cs_prev_q;
    logic              bus_live;
    logic              sck_rise;
    logic              sck_fall;
    logic              cmd_start;
    logic              cmd_end;
    fsm_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        wr_byte;
    logic              arr_we_req;
    logic              stat_we_req;
    logic              latch_set;
    logic              latch_clr;
    logic              latch_q;
    logic [1:0]        prot_q;
    logic [7:0]        status_byte;
    logic              arr_wr_ok;
    logic              arr_we;
    logic [7:0]        arr_rdata;

    spimem_sync #(
        .W       (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (5'b11100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({wp_n, hold_n, cs_n, sck, si}),
        .q     (pins_s)
    );

    assign {wp_s, hold_s, cs_s, sck_s, si_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev_q <= 1'b0;
            cs_prev_q  <= 1'b1;
        end else begin
            sck_prev_q <= sck_s;
            if (hold_s) begin
                cs_prev_q <= cs_s;
            end
        end
    end

    assign bus_live  = !cs_s && hold_s;
    assign sck_rise  = bus_live && sck_s && !sck_prev_q;
    assign sck_fall  = bus_live && !sck_s && sck_prev_q;
    assign cmd_start = hold_s && cs_prev_q && !cs_s;
    assign cmd_end   = hold_s && !cs_prev_q && cs_s;

    spimem_fsm #(
        .ADDR_W  (ADDR_W),
        .FIELD_W (FIELD_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_rise    (sck_rise),
        .sck_fall    (sck_fall),
        .cmd_start   (cmd_start),
        .cmd_end     (cmd_end),
        .bus_live    (bus_live),
        .si          (si_s),
        .status_byte (status_byte),
        .arr_rdata   (arr_rdata),
        .state_q     (state_q),
        .addr_q      (addr_q),
        .wr_byte     (wr_byte),
        .arr_we_req  (arr_we_req),
        .stat_we_req (stat_we_req),
        .latch_set   (latch_set),
        .latch_clr   (latch_clr),
        .so          (so),
        .so_en       (so_en)
    );

    spimem_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .latch_set   (latch_set),
        .latch_clr   (latch_clr),
        .stat_we_req (stat_we_req),
        .stat_wbits  (wr_byte[3:2]),
        .wp_ok       (wp_s),
        .addr_top    (addr_q[ADDR_W-1:ADDR_W-2]),
        .latch_q     (latch_q),
        .prot_q      (prot_q),
        .status_byte (status_byte),
        .arr_wr_ok   (arr_wr_ok)
    );

    assign arr_we = arr_we_req && arr_wr_ok;

    spimem_array #(
        .STORE_AW (STORE_AW),
        .DATA_W   (8)
    ) u_array (
        .clk   (clk),
        .we    (arr_we),
        .idx   (addr_q[STORE_AW-1:0]),
        .wdata (wr_byte),
        .rdata (arr_rdata)
    );

endmodule

// File: rtl/spimem_chk.sv
module spimem_chk
    import spimem_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              hold_s,
    input  logic              wp_s,
    input  logic              so_en,
    input  logic [1:0]        prot_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic              arr_we_req,
    input  fsm_state_e        state_q
);

    // R1
    cs_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !so_en);

    // R9
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_s |=> !so_en);

    // R4
    drive_only_reading_chk: assert property (@(posedge clk) disable iff (!rst_n)
        so_en |-> (state_q == ST_RDDATA || state_q == ST_SRRD));

    // R7
    wp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_s |=> $stable(prot_q));

    // R6
    addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we_req && (&addr_q)) |=> (addr_q == '0));

endmodule

bind spimem_slave spimem_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_s       (cs_s),
    .hold_s     (hold_s),
    .wp_s       (wp_s),
    .so_en      (so_en),
    .prot_q     (prot_q),
    .addr_q     (addr_q),
    .arr_we_req (arr_we_req),
    .state_q    (state_q)
);

// File: tb/tb_spimem_slave.sv
module tb_spimem_slave;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    typedef struct packed {
        logic        is_wr;
        logic [15:0] addr;
        logic [7:0]  data;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 16'h0040, 8'h11},
        '{1'b1, 16'h1900, 8'h33},
        '{1'b1, 16'h0123, 8'hA5},
        '{1'b1, 16'h0600, 8'h3C},
        '{1'b0, 16'h0040, 8'h11},
        '{1'b0, 16'h1900, 8'h33},
        '{1'b0, 16'hE123, 8'hA5},
        '{1'b0, 16'h0600, 8'h3C}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic hold_n = 1'b1;
    logic wp_n = 1'b1;
    logic so;
    logic so_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spimem_slave dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .sck    (sck),
        .si     (si),
        .hold_n (hold_n),
        .wp_n   (wp_n),
        .so     (so),
        .so_en  (so_en)
    );

    task automatic wait_half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bit_io(input logic b, output logic r);
        si = b;
        r = so_en ? so : 1'bx;
        sck = 1'b1;
        wait_half();
        sck = 1'b0;
        wait_half();
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            bit_io(tx[i], rx[i]);
        end
    endtask

    task automatic send(input logic [7:0] tx);
        logic [7:0] dummy;
        xfer(tx, dummy);
    endtask

    task automatic cmd_open();
        cs_n = 1'b0;
        wait_half();
    endtask

    task automatic cmd_close();
        cs_n = 1'b1;
        wait_half();
        wait_half();
    endtask

    task automatic one_byte_cmd(input logic [7:0] op);
        cmd_open();
        send(op);
        cmd_close();
    endtask

    task automatic stat_read(output logic [7:0] s);
        cmd_open();
        send(8'h05);
        xfer(8'h00, s);
        cmd_close();
    endtask

    task automatic stat_write(input logic [7:0] v);
        cmd_open();
        send(8'h01);
        send(v);
        cmd_close();
    endtask

    task automatic arr_write(input logic [15:0] a, input logic [7:0] d);
        cmd_open();
        send(8'h02);
        send(a[15:8]);
        send(a[7:0]);
        send(d);
        cmd_close();
    endtask

    task automatic arr_read(input logic [15:0] a, output logic [7:0] d);
        cmd_open();
        send(8'h03);
        send(a[15:8]);
        send(a[7:0]);
        xfer(8'h00, d);
        cmd_close();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] v2;
        logic       b;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R11: reset state
        check8("R11 so_en after reset", {7'b0, so_en}, 8'h00);
        stat_read(v);
        check8("R11 status after reset", v, 8'h00);

        // R1: pulses with chip select high carry a latch-on command that must vanish
        for (int i = 7; i >= 0; i--) begin
            si = (8'h06 >> i) & 1'b1;
            sck = 1'b1;
            wait_half();
            sck = 1'b0;
            wait_half();
        end
        check8("R1 so_en while deselected", {7'b0, so_en}, 8'h00);
        stat_read(v);
        check8("R1 status after deselected pulses", v, 8'h00);

        // R3: latch on and off
        one_byte_cmd(8'h06);
        stat_read(v);
        check8("R3 latch on reads 0x02", v, 8'h02);
        one_byte_cmd(8'h04);
        stat_read(v);
        check8("R3 latch off reads 0x00", v, 8'h00);

        // R4 R5: vector table
        for (int k = 0; k < 8; k++) begin
            if (VECS[k].is_wr) begin
                one_byte_cmd(8'h06);
                arr_write(VECS[k].addr, VECS[k].data);
            end else begin
                arr_read(VECS[k].addr, v);
                check8($sformatf("R4 table read %h", VECS[k].addr), v, VECS[k].data);
            end
        end

        // R5: write without the latch is dropped, latch clears after a write
        arr_write(16'h0040, 8'h5A);
        arr_read(16'h0040, v);
        check8("R5 write without latch dropped", v, 8'h11);
        one_byte_cmd(8'h06);
        arr_write(16'h0300, 8'h77);
        stat_read(v);
        check8("R5 latch cleared after write", v, 8'h00);
        arr_read(16'h0300, v);
        check8("R5 latched write stored", v, 8'h77);

        // R7: write-protect pin freezes status
        wp_n = 1'b0;
        one_byte_cmd(8'h06);
        stat_write(8'h0C);
        wp_n = 1'b1;
        wait_half();
        stat_read(v);
        check8("R7 status write blocked by pin", v, 8'h00);
        one_byte_cmd(8'h06);
        stat_write(8'h04);
        stat_read(v);
        check8("R7 status write accepted", v, 8'h04);

        // R8: protect regions
        one_byte_cmd(8'h06);
        arr_write(16'h1900, 8'hAA);
        arr_read(16'h1900, v);
        check8("R8 quarter blocks 0x1900", v, 8'h33);
        one_byte_cmd(8'h06);
        arr_write(16'h0200, 8'h5C);
        arr_read(16'h0200, v);
        check8("R8 quarter allows 0x0200", v, 8'h5C);
        one_byte_cmd(8'h06);
        stat_write(8'h0C);
        one_byte_cmd(8'h06);
        arr_write(16'h0200, 8'h99);
        arr_read(16'h0200, v);
        check8("R8 all blocks 0x0200", v, 8'h5C);
        one_byte_cmd(8'h06);
        stat_write(8'h08);
        one_byte_cmd(8'h06);
        arr_write(16'h0FFF, 8'h21);
        arr_read(16'h0FFF, v);
        check8("R8 half allows 0x0FFF", v, 8'h21);
        one_byte_cmd(8'h06);
        arr_write(16'h1900, 8'hBB);
        arr_read(16'h1900, v);
        check8("R8 half blocks 0x1900", v, 8'h33);
        one_byte_cmd(8'h06);
        stat_write(8'h00);

        // R6: burst wrap in both directions
        one_byte_cmd(8'h06);
        cmd_open();
        send(8'h02);
        send(8'h1F);
        send(8'hFF);
        send(8'h71);
        send(8'h72);
        cmd_close();
        arr_read(16'h0000, v);
        check8("R6 write burst wrapped to 0x0000", v, 8'h72);
        cmd_open();
        send(8'h03);
        send(8'h1F);
        send(8'hFF);
        xfer(8'h00, v);
        xfer(8'h00, v2);
        cmd_close();
        check8("R6 read burst first byte", v, 8'h71);
        check8("R6 read burst wrapped byte", v2, 8'h72);

        // R2: truncated write stores nothing and still clears the latch
        one_byte_cmd(8'h06);
        arr_write(16'h0050, 8'h44);
        one_byte_cmd(8'h06);
        cmd_open();
        send(8'h02);
        check8("R4 so_en low during write command", {7'b0, so_en}, 8'h00);
        send(8'h00);
        send(8'h50);
        for (int i = 0; i < 4; i++) begin
            bit_io(1'b1, b);
        end
        cmd_close();
        arr_read(16'h0050, v);
        check8("R2 truncated byte discarded", v, 8'h44);
        stat_read(v);
        check8("R2 latch cleared after aborted write", v, 8'h00);

        // R9 R10: hold in mid-byte with ignored pulses, then a long pause
        one_byte_cmd(8'h06);
        arr_write(16'h0060, 8'hC3);
        cmd_open();
        send(8'h03);
        check8("R4 so_en low after read opcode", {7'b0, so_en}, 8'h00);
        send(8'h00);
        send(8'h60);
        check8("R4 so_en high in read data", {7'b0, so_en}, 8'h01);
        for (int i = 7; i >= 5; i--) begin
            bit_io(1'b0, v[i]);
        end
        hold_n = 1'b0;
        wait_half();
        check8("R9 so_en low during hold", {7'b0, so_en}, 8'h00);
        for (int i = 0; i < 4; i++) begin
            sck = 1'b1;
            wait_half();
            sck = 1'b0;
            wait_half();
        end
        hold_n = 1'b1;
        repeat (300) @(negedge clk);
        for (int i = 4; i >= 0; i--) begin
            bit_io(1'b0, v[i]);
        end
        cmd_close();
        check8("R9 R10 read resumes after hold and pause", v, 8'hC3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule